// File: doc/BRIEF.md
# Echo Delay Line with Darkening Feedback

This block is a streaming echo effect for signed 24-bit audio samples arriving at an audio rate well below the clock rate, typically 48 kHz. Each sample that enters is stored in an on-chip ring buffer. The block then reads back the sample stored a programmable number of samples earlier and adds a scaled copy of it to the dry input to form the output. A feedback path passes the delayed signal through a one-pole low-pass filter. It scales the result and adds it to the input before the sum is stored. Because the filtered signal goes back into the buffer, each repeat is duller than the one before it.

Control inputs set the delay length in samples, the feedback amount, the tone (filter coefficient) and the wet mix level. A bypass input sends the dry sample straight to the output while the buffer and filter keep running. The buffer depth is a parameter. Setting it to 48000 gives one second of history at 48 kHz. After reset the block treats the whole history as silence, so no stale memory contents ever reach the output.

Top module: `echo_delay_fx`

## Requirements
- R1: The effective delay length L is `delay_len` clamped to the range 1..MAX_DELAY: a value of 0 acts as 1, and any value above MAX_DELAY acts as MAX_DELAY.
- R2: A sample accepted with `in_valid` high in cycle t produces `out_valid` high for exactly one cycle, registered at the second rising edge after t. `out_valid` is low in cycle t+1.
- R3: The delayed sample d is zero until at least L samples have been stored since reset. After that, d is the value stored L samples earlier.
- R4: With bypass low, `sample_out` = sat(x + floor(m·d/256)). Here x is the input sample and m is `mix_gain` read as an unsigned 8-bit integer.
- R5: The value stored for each sample is sat(x + floor(f·y/256)). Here f is `fb_gain` (unsigned 8-bit) and y is the tone filter state after this sample's update.
- R6: For every sample the tone filter updates y ← y + floor((k+1)·(d − y)/256), where k is `tone_k` (unsigned 8-bit). At k = 255, y equals d.
- R7: With bypass high, `sample_out` equals the input sample exactly. The buffer and filter keep updating, so echoes resume when bypass goes low.
- R8: sat() clamps to the signed 24-bit range −8388608..8388607.
- R9: `in_valid` is never high in two consecutive cycles. Samples spaced two cycles apart are all processed correctly, including at L = 1.
- R10: Reset clears `out_valid` and `sample_out` to 0 at the next edge, empties the stored history, and sets the filter state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: a new input sample is present |
| sample_in | input | 24 | Signed input sample |
| delay_len | input | LEN_W (16) | Delay length in samples, clamped to 1..MAX_DELAY |
| fb_gain | input | 8 | Feedback amount, unsigned, scale f/256 |
| tone_k | input | 8 | Tone filter coefficient, step (k+1)/256 |
| mix_gain | input | 8 | Wet level added to the dry sample, scale m/256 |
| bypass | input | 1 | High: output the dry sample unchanged |
| out_valid | output | 1 | Registered strobe for `sample_out` |
| sample_out | output | 24 | Signed, saturated output sample |

## Verification
The bench builds the block with MAX_DELAY = 40 and the default LEN_W = 16. At that depth the write pointer wraps, reads from a full buffer occur, and a length of 1000 is clamped to the buffer depth, all within a few dozen samples. The bench runs a behavioural model in parallel with the design: an array that stands for the history, a fill count and a filter state. It drives long feedback tails at low tone settings, near-full-scale inputs that push both the stored value and the output into saturation, and a burst at the minimum two-cycle sample spacing with a length of 1. It then resets the block in the middle of a run and checks that the echoes start again from silence.

// File: rtl/echo_pkg.sv
package echo_pkg;
  localparam int ACC_W  = 48;
  localparam int GAIN_W = 8;

  typedef logic signed [ACC_W-1:0] acc_t;

  // a * g / 2^GAIN_W with floor rounding
  function automatic acc_t scale_q8(acc_t a, logic [GAIN_W-1:0] g);
    acc_t gw;
    gw = acc_t'({1'b0, g});
    return (a * gw) >>> GAIN_W;
  endfunction

  function automatic int unsigned clamp_len(int unsigned len, int unsigned maxv);
    if (len == 0)   return 1;
    if (len > maxv) return maxv;
    return len;
  endfunction
endpackage

// File: rtl/echo_addr_gen.sv
module echo_addr_gen import echo_pkg::*; #(
  parameter int MAX_DELAY = 2048,
  parameter int LEN_W     = 16,
  localparam int AW = $clog2(MAX_DELAY),
  localparam int FW = $clog2(MAX_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [LEN_W-1:0] delay_len,
  input  logic             adv,
  output logic [AW-1:0]    raddr,
  output logic [AW-1:0]    waddr,
  output logic             hit
);
  logic [AW-1:0] wp;
  logic [FW-1:0] fill;
  logic [FW-1:0] len_c;

  always_comb begin
    int unsigned diff;
    len_c = FW'(clamp_len(32'(delay_len), MAX_DELAY));
    diff  = 32'(wp) + MAX_DELAY - 32'(len_c);
    if (diff >= MAX_DELAY) diff = diff - MAX_DELAY;
    raddr = AW'(diff);
  end

  assign hit   = (fill >= len_c);
  assign waddr = wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      fill <= '0;
    end else if (adv) begin
      wp <= (32'(wp) == MAX_DELAY - 1) ? '0 : wp + 1'b1;
      if (32'(fill) != MAX_DELAY) fill <= fill + 1'b1;
    end
  end

  // R1: read and write addresses stay inside the ring
  a_r1_addr_in_ring: assert property (@(posedge clk) disable iff (rst)
    req |-> (32'(raddr) < MAX_DELAY && 32'(wp) < MAX_DELAY));

  // R3: nothing is considered stored right after reset
  a_r3_empty_after_reset: assert property (@(posedge clk)
    rst |=> !hit);
endmodule

// File: rtl/echo_ring_store.sv
module echo_ring_store #(
  parameter int D_W   = 24,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [D_W-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [D_W-1:0] rdata
);
  logic [D_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/echo_tone_lpf.sv
module echo_tone_lpf import echo_pkg::*; #(
  parameter int D_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [D_W-1:0]  x,
  input  logic [GAIN_W-1:0]      k,
  output logic signed [D_W-1:0]  y_next
);
  logic signed [D_W-1:0] y_q;

  function automatic logic signed [D_W-1:0] lp_step(
    logic signed [D_W-1:0] xi, logic signed [D_W-1:0] yi, logic [GAIN_W-1:0] ki);
    acc_t diff, coef, nxt;
    diff = acc_t'(xi) - acc_t'(yi);
    coef = acc_t'({1'b0, ki}) + acc_t'(1);
    nxt  = acc_t'(yi) + ((diff * coef) >>> GAIN_W);
    return nxt[D_W-1:0];
  endfunction

  assign y_next = lp_step(x, y_q, k);

  always_ff @(posedge clk) begin
    if (rst)     y_q <= '0;
    else if (en) y_q <= y_next;
  end

  // R6: each update moves the state toward the input without overshoot
  a_r6_no_overshoot: assert property (@(posedge clk) disable iff (rst)
    en |=> (($past(x) >= $past(y_q)) ?
            (y_q >= $past(y_q) && y_q <= $past(x)) :
            (y_q <= $past(y_q) && y_q >= $past(x))));
endmodule

// File: rtl/echo_delay_fx.sv
module echo_delay_fx import echo_pkg::*; #(
  parameter int D_W       = 24,
  parameter int MAX_DELAY = 2048,
  parameter int LEN_W     = 16,
  localparam int AW = $clog2(MAX_DELAY)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [D_W-1:0] sample_in,
  input  logic [LEN_W-1:0]      delay_len,
  input  logic [GAIN_W-1:0]     fb_gain,
  input  logic [GAIN_W-1:0]     tone_k,
  input  logic [GAIN_W-1:0]     mix_gain,
  input  logic                  bypass,
  output logic                  out_valid,
  output logic signed [D_W-1:0] sample_out
);
  localparam acc_t SAT_HI = (acc_t'(1) <<< (D_W - 1)) - acc_t'(1);
  localparam acc_t SAT_LO = -(acc_t'(1) <<< (D_W - 1));

  function automatic logic signed [D_W-1:0] sat(acc_t v);
    acc_t r;
    if (v > SAT_HI)      r = SAT_HI;
    else if (v < SAT_LO) r = SAT_LO;
    else                 r = v;
    return r[D_W-1:0];
  endfunction

  logic [AW-1:0]         raddr, waddr;
  logic                  hit, hit1, v1;
  logic signed [D_W-1:0] x1, rdata, dly, y_next, wdata;

  echo_addr_gen #(.MAX_DELAY(MAX_DELAY), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst(rst), .req(in_valid), .delay_len(delay_len),
    .adv(v1), .raddr(raddr), .waddr(waddr), .hit(hit));

  echo_ring_store #(.D_W(D_W), .DEPTH(MAX_DELAY)) u_store (
    .clk(clk), .we(v1), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata));

  // stage 0: address issue, capture input
  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      hit1 <= 1'b0;
      x1   <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        hit1 <= hit;
        x1   <= sample_in;
      end
    end
  end

  // stage 1: filter, write back, mix
  assign dly = hit1 ? rdata : '0;

  echo_tone_lpf #(.D_W(D_W)) u_tone (
    .clk(clk), .rst(rst), .en(v1), .x(dly), .k(tone_k), .y_next(y_next));

  assign wdata = sat(acc_t'(x1) + scale_q8(acc_t'(y_next), fb_gain));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      sample_out <= '0;
    end else begin
      out_valid <= v1;
      if (v1)
        sample_out <= bypass ? x1 : sat(acc_t'(x1) + scale_q8(acc_t'(dly), mix_gain));
    end
  end

  // R9: input strobes are spaced at least two cycles apart
  a_r9_spacing: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !in_valid);

  // R2: result appears on the second edge, not the first
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !out_valid ##1 out_valid);

  // R7: bypassed samples come out unchanged
  a_r7_bypass_dry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass) ##1 bypass |=> sample_out == $past(sample_in, 2));

  // R10: reset clears the outputs
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && sample_out == '0));
endmodule

// File: tb/test_echo_delay_fx.sv
`timescale 1ns/1ps
module test_echo_delay_fx;
  localparam int MAXD = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [23:0] sample_in = '0;
  logic [15:0] delay_len = 16'd5;
  logic [7:0] fb_gain = '0, tone_k = 8'd255, mix_gain = 8'd128;
  logic bypass = 1'b0;
  logic out_valid;
  logic signed [23:0] sample_out;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  longint mem_m [MAXD];
  int wp_m = 0, fill_m = 0;
  longint y_m = 0;

  always #5 clk = ~clk;

  echo_delay_fx #(.D_W(24), .MAX_DELAY(MAXD), .LEN_W(16)) i_echo_delay_fx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sample_in(sample_in),
    .delay_len(delay_len), .fb_gain(fb_gain), .tone_k(tone_k),
    .mix_gain(mix_gain), .bypass(bypass), .out_valid(out_valid),
    .sample_out(sample_out));

  function automatic longint sat24(longint v);
    if (v > 8388607)  return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic longint model_step(longint x);
    int L;
    longint d;
    L = (delay_len == 0) ? 1 : ((int'(delay_len) > MAXD) ? MAXD : int'(delay_len));
    d = (fill_m >= L) ? mem_m[(wp_m - L + MAXD) % MAXD] : 0;
    y_m = y_m + ((longint'(tone_k) + 1) * (d - y_m) >>> 8);
    mem_m[wp_m] = sat24(x + ((longint'(fb_gain) * y_m) >>> 8));
    wp_m = (wp_m + 1) % MAXD;
    if (fill_m < MAXD) fill_m++;
    return bypass ? x : sat24(x + ((longint'(mix_gain) * d) >>> 8));
  endfunction

  task automatic check(string tag, longint got, longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // one sample with four-cycle spacing
  task automatic send(longint x, string tag);
    longint exp;
    @(negedge clk);
    in_valid = 1'b1; sample_in = 24'(x);
    exp = model_step(x);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " (R2 no early valid)"}, out_valid, 0);
    @(negedge clk);
    check({tag, " valid"}, out_valid, 1);
    check(tag, sample_out, exp);
    @(negedge clk);
    check({tag, " (R2 one-cycle valid)"}, out_valid, 0);
  endtask

  // samples at the minimum two-cycle spacing
  task automatic burst2(int n, longint base);
    longint exp_prev = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R9 burst valid", out_valid, 1);
        check("R9 burst data", sample_out, exp_prev);
      end
      in_valid = 1'b1; sample_in = 24'(base * (i + 1));
      exp_prev = model_step(base * (i + 1));
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 gap", out_valid, 0);
    end
    @(negedge clk);
    check("R9 burst last", sample_out, exp_prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", out_valid, 0);
    check("R10 reset data", sample_out, 0);
    rst = 1'b0;

    // R3 / R4: silence before L samples, then plain echo
    delay_len = 16'd5; fb_gain = 8'd0; tone_k = 8'd255; mix_gain = 8'd128;
    for (int i = 0; i < 12; i++)
      send(((i % 2) ? -1 : 1) * 1000 * (i + 1), (i < 5) ? "R3" : "R4");

    // R5: feedback repeats
    delay_len = 16'd3; fb_gain = 8'd192; mix_gain = 8'd255;
    send(400000, "R5");
    for (int i = 0; i < 15; i++) send(0, "R5");

    // R6: darkening repeats through the tone filter
    delay_len = 16'd4; fb_gain = 8'd230; tone_k = 8'd20;
    send(-600000, "R6");
    for (int i = 0; i < 20; i++) send(0, "R6");

    // R8: saturation on stored value and output
    delay_len = 16'd2; fb_gain = 8'd255; tone_k = 8'd255; mix_gain = 8'd255;
    for (int i = 0; i < 6; i++) send(8388000, "R8");
    for (int i = 0; i < 6; i++) send(-8388000, "R8");

    // R1: clamp low and high, ring wrap
    fb_gain = 8'd100; mix_gain = 8'd200; tone_k = 8'd128;
    delay_len = 16'd0;
    for (int i = 0; i < 6; i++) send(5000 * (i + 1), "R1");
    delay_len = 16'd1000;
    for (int i = 0; i < 45; i++) send(3000 * (i - 20), "R1");

    // R7: bypass passes dry while history keeps running
    delay_len = 16'd3;
    bypass = 1'b1;
    for (int i = 0; i < 10; i++) send(-7000 * (i + 1), "R7");
    bypass = 1'b0;
    for (int i = 0; i < 8; i++) send(0, "R7");

    // R9: minimum spacing at length 1
    delay_len = 16'd1; fb_gain = 8'd64; mix_gain = 8'd255;
    burst2(10, 11111);

    // R10: reset in mid-run empties history and filter
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset valid", out_valid, 0);
    check("R10 mid reset data", sample_out, 0);
    rst = 1'b0;
    wp_m = 0; fill_m = 0; y_m = 0;
    delay_len = 16'd3; fb_gain = 8'd128; tone_k = 8'd255; mix_gain = 8'd255;
    for (int i = 0; i < 8; i++) send(20000 * (i + 1), "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule